// File: doc/BRIEF.md
# Serial LCD Command Frame Transmitter

This block takes one payload byte and a register-select flag from an upstream producer over a valid/ready handshake. It sends them to a serial-mode LCD controller as a 24-bit frame on a clock line and a data line. Every frame opens with a synchronisation byte that carries the write direction and the register-select flag. The payload follows as two nibble bytes, and each nibble byte has four zero bits after it. The block only writes. The caller must wait out any settling time the controller needs after a command.

The serial clock comes from the system clock. Each of its half periods lasts a fixed, parameterised number of system clocks. The data line changes only while the clock is low and is stable for the whole high phase, so the controller can take each bit on the rising edge. An optional chip-select output frames the transfer. It rises half a serial period before the first rising edge and falls half a serial period after the last falling edge.

Top module: `lcd_serial_tx`

## Requirements
- R1: The first eight serial bits of a frame, in send order, are 1,1,1,1,1,0,RS,0. The 0 in the sixth position is the write direction. RS is the `in_rs` value captured at acceptance, so a command gives 0xF8 and a data write gives 0xFA.
- R2: Bits 9 to 16 carry the payload bits 7,6,5,4 in that order, followed by four 0 bits.
- R3: Bits 17 to 24 carry the payload bits 3,2,1,0 in that order, followed by four 0 bits.
- R4: `lcd_sdata` changes only while `lcd_sclk` is low. It does not change during any cycle in which `lcd_sclk` stays high.
- R5: Every low phase and every high phase of `lcd_sclk` within a frame lasts exactly HALF_PERIOD_CLKS system clocks. The first rising edge comes HALF_PERIOD_CLKS clocks after acceptance. `done` appears 49×HALF_PERIOD_CLKS clocks after the accepting edge.
- R6: After reset, and whenever no frame is in progress, `in_ready`=1, `busy`=0, `done`=0, and `lcd_sclk`, `lcd_sdata` and `lcd_cs` are all 0. A reset during a frame returns the block to this state.
- R7: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle until the frame completes, `in_ready`=0 and `busy`=1. Activity on `in_valid`, `in_data` and `in_rs` during that time does not change the frame being sent.
- R8: `done` is high for exactly one cycle, in the same cycle that `in_ready` returns to 1 and `busy` returns to 0.
- R9: With USE_CS=1, `lcd_cs` is 1 from the cycle after acceptance until the cycle `done` is high, when it is 0. That covers half a period before the first bit and half a period after the last one. With USE_CS=0, `lcd_cs` stays 0.
- R10: Each frame produces exactly 24 rising edges of `lcd_sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Command or display-data byte |
| in_rs | input | 1 | Register select: 0 command, 1 data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame completion |
| lcd_sclk | output | 1 | Serial clock to the LCD, idles low |
| lcd_sdata | output | 1 | Serial data to the LCD |
| lcd_cs | output | 1 | Chip select, active high (0 when unused) |

## Verification
The bench collects the frame on every rising edge of `lcd_sclk`. It compares the three bytes separately, which catches a design that swaps the nibbles, sends bits LSB-first, or puts RS in the wrong slot. It times every clock phase and the distance to `done`, so an off-by-one in the half-period counter or a missing trailing half period shows up as a wrong length. In one test the producer toggles `in_valid` with other data during the frame; a design that re-accepted input mid-frame would corrupt the captured frame. The bench also resets in the middle of a frame, which catches state that survives reset. A second instance without chip select must keep `lcd_cs` low.

// File: rtl/lcd_tx_pkg.sv
package lcd_tx_pkg;
  localparam int PAYLOAD_BITS = 8;
  localparam int NIB_BITS     = PAYLOAD_BITS / 2;
  localparam int SYNC_ONES    = 5;
  localparam int FRAME_BITS   = 3 * PAYLOAD_BITS;
  localparam int IDX_W        = $clog2(FRAME_BITS);

  typedef logic [FRAME_BITS-1:0]   frame_t;
  typedef logic [PAYLOAD_BITS-1:0] payload_t;

  // Frame in send order, MSB first: sync ones, RW=0, RS, 0,
  // high nibble + zero pad, low nibble + zero pad.
  function automatic frame_t build_frame(input logic rs, input payload_t pl);
    return {{SYNC_ONES{1'b1}}, 1'b0, rs, 1'b0,
            pl[PAYLOAD_BITS-1:NIB_BITS], {NIB_BITS{1'b0}},
            pl[NIB_BITS-1:0],            {NIB_BITS{1'b0}}};
  endfunction
endpackage

// File: rtl/lcd_half_tick.sv
module lcd_half_tick #(
  parameter int HALF_PERIOD_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_PERIOD_CLKS > 1) ? $clog2(HALF_PERIOD_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  if (HALF_PERIOD_CLKS > 1) begin : g_spacing
    // R5: two half-period boundaries are never adjacent
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end
endmodule

// File: rtl/lcd_frame_shift.sv
module lcd_frame_shift
  import lcd_tx_pkg::*;
#(
  parameter int HALF_PERIOD_CLKS = 4,
  parameter bit USE_CS           = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  logic     in_rs,
  input  payload_t in_data,
  input  logic     tick,
  output logic     in_ready,
  output logic     busy,
  output logic     done,
  output logic     sclk,
  output logic     sdata,
  output logic     cs
);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

  frame_t           sreg;
  logic [IDX_W-1:0] bit_idx;
  logic             tail_q, ready_q, busy_q, done_q, sclk_q, sdata_q;

  frame_t next_frame;
  assign next_frame = build_frame(in_rs, in_data);

  logic accept, finish;
  assign accept = ready_q && in_valid;
  assign finish = busy_q && tick && tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      bit_idx <= '0;
      tail_q  <= 1'b0;
      ready_q <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        sreg    <= next_frame;
        sdata_q <= next_frame[FRAME_BITS-1];
        bit_idx <= '0;
        tail_q  <= 1'b0;
        sclk_q  <= 1'b0;
        ready_q <= 1'b0;
        busy_q  <= 1'b1;
      end else if (busy_q && tick) begin
        if (tail_q) begin
          tail_q  <= 1'b0;
          busy_q  <= 1'b0;
          ready_q <= 1'b1;
          done_q  <= 1'b1;
          sdata_q <= 1'b0;
        end else if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bit_idx == LAST_BIT) begin
            tail_q <= 1'b1;
          end else begin
            sreg    <= sreg << 1;
            sdata_q <= sreg[FRAME_BITS-2];
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end

  assign in_ready = ready_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign sclk     = sclk_q;
  assign sdata    = sdata_q;

  if (USE_CS) begin : g_cs
    logic cs_q;
    always_ff @(posedge clk) begin
      if (rst)         cs_q <= 1'b0;
      else if (accept) cs_q <= 1'b1;
      else if (finish) cs_q <= 1'b0;
    end
    assign cs = cs_q;

    // R9: select covers every clock pulse and is gone by completion
    a_r9_cs_covers_clock: assert property (@(posedge clk) disable iff (rst)
      sclk_q |-> cs_q);
    a_r9_cs_off_at_done: assert property (@(posedge clk) disable iff (rst)
      done_q |-> !cs_q);
  end else begin : g_no_cs
    assign cs = 1'b0;
  end

  // Phase-length monitor for R5 (high phase measured at each falling edge)
  logic        sclk_d;
  logic [31:0] ph_cnt;
  always_ff @(posedge clk) begin
    sclk_d <= sclk_q;
    if (rst || (sclk_q != sclk_d)) ph_cnt <= 32'd1;
    else                           ph_cnt <= ph_cnt + 32'd1;
  end

  a_r5_high_phase_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_q) |-> (ph_cnt == 32'(HALF_PERIOD_CLKS)));
  a_r4_data_hold_high: assert property (@(posedge clk) disable iff (rst)
    sclk_q |=> (!sclk_q || $stable(sdata_q)));
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!sclk_q && !sdata_q));
  a_r7_ready_busy_excl: assert property (@(posedge clk) disable iff (rst)
    !(ready_q && busy_q));
  a_r7_start_needs_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(in_valid));
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r8_done_with_ready: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (ready_q && !busy_q));
  a_r10_index_range: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= LAST_BIT);
endmodule

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx
  import lcd_tx_pkg::*;
#(
  parameter int HALF_PERIOD_CLKS = 4,
  parameter bit USE_CS           = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_rs,
  output logic       busy,
  output logic       done,
  output logic       lcd_sclk,
  output logic       lcd_sdata,
  output logic       lcd_cs
);
  logic tick;

  lcd_half_tick #(.HALF_PERIOD_CLKS(HALF_PERIOD_CLKS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .tick (tick)
  );

  lcd_frame_shift #(
    .HALF_PERIOD_CLKS(HALF_PERIOD_CLKS),
    .USE_CS          (USE_CS)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_rs    (in_rs),
    .in_data  (in_data),
    .tick     (tick),
    .in_ready (in_ready),
    .busy     (busy),
    .done     (done),
    .sclk     (lcd_sclk),
    .sdata    (lcd_sdata),
    .cs       (lcd_cs)
  );
endmodule

// File: tb/test_lcd_serial_tx.sv
module test_lcd_serial_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int FRAME_CYC  = 49 * HALF;
  localparam int WD_LIMIT   = 50000;
  localparam int NV         = 8;

  // {rs, payload, expected 24-bit frame in send order}
  localparam logic [32:0] VECS [NV] = '{
    {1'b0, 8'h30, 24'hF83000},
    {1'b0, 8'h01, 24'hF80010},
    {1'b0, 8'h06, 24'hF80060},
    {1'b0, 8'h0C, 24'hF800C0},
    {1'b1, 8'h41, 24'hFA4010},
    {1'b1, 8'hFF, 24'hFAF0F0},
    {1'b0, 8'h00, 24'hF80000},
    {1'b1, 8'hA5, 24'hFAA050}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_rs = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, busy, done, lcd_sclk, lcd_sdata, lcd_cs;
  logic n_ready, n_busy, n_done, n_sclk, n_sdata, n_cs;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_serial_tx #(.HALF_PERIOD_CLKS(HALF), .USE_CS(1'b1)) i_lcd_serial_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_rs(in_rs), .busy(busy), .done(done),
    .lcd_sclk(lcd_sclk), .lcd_sdata(lcd_sdata), .lcd_cs(lcd_cs));

  lcd_serial_tx #(.HALF_PERIOD_CLKS(HALF), .USE_CS(1'b0)) i_lcd_serial_tx_nocs (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(n_ready),
    .in_data(in_data), .in_rs(in_rs), .busy(n_busy), .done(n_done),
    .lcd_sclk(n_sclk), .lcd_sdata(n_sdata), .lcd_cs(n_cs));

  int n_checks = 0;
  int n_fail   = 0;
  int wd       = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", wd, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic check_idle(input string tag);
    check(in_ready === 1'b1, {tag, " in_ready"}, 32'(in_ready), 1);
    check(busy === 1'b0,     {tag, " busy"},     32'(busy), 0);
    check(done === 1'b0,     {tag, " done"},     32'(done), 0);
    check({lcd_sclk, lcd_sdata, lcd_cs} === 3'b000, {tag, " lines"},
          32'({lcd_sclk, lcd_sdata, lcd_cs}), 0);
  endtask

  task automatic run_frame(input logic rs, input logic [7:0] data,
                           input logic [23:0] exp, input bit poke);
    logic [23:0] got = '0;
    int rises = 0;
    int last_tog = 1;
    logic prev_sclk = 1'b0;
    logic hold_bit = 1'b0;
    bit hold_ok = 1, phase_ok = 1, ready_ok = 1, cs_ok = 1, nocs_ok = 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_rs = rs; in_data = data;
    for (int cyc = 1; cyc <= FRAME_CYC + 1; cyc++) begin
      @(negedge clk);
      if (cyc == 1) begin
        in_valid = 1'b0; in_rs = ~rs; in_data = ~data;
      end
      if (poke) begin
        in_valid = (cyc >= 10 && cyc < 20);
        in_data  = 8'h55;
        in_rs    = ~rs;
      end
      if (lcd_sclk && !prev_sclk) begin
        got = {got[22:0], lcd_sdata};
        rises++;
        hold_bit = lcd_sdata;
      end
      if (lcd_sclk && prev_sclk && (lcd_sdata !== hold_bit)) hold_ok = 0;
      if (lcd_sclk !== prev_sclk) begin
        if (cyc - last_tog != HALF) phase_ok = 0;
        last_tog = cyc;
      end
      if (cyc <= FRAME_CYC) begin
        if (in_ready !== 1'b0 || busy !== 1'b1 || done !== 1'b0) ready_ok = 0;
        if (lcd_cs !== 1'b1) cs_ok = 0;
      end
      if (n_cs !== 1'b0) nocs_ok = 0;
      prev_sclk = lcd_sclk;
    end
    // R1/R2/R3: frame contents byte by byte
    check(got[23:16] === exp[23:16], "R1 sync byte", 32'(got[23:16]), 32'(exp[23:16]));
    check(got[15:8]  === exp[15:8],  "R2 high nibble byte", 32'(got[15:8]), 32'(exp[15:8]));
    check(got[7:0]   === exp[7:0],   "R3 low nibble byte", 32'(got[7:0]), 32'(exp[7:0]));
    check(rises == 24, "R10 rising edges", 32'(rises), 24);
    check(hold_ok, "R4 data stable while clock high", 32'(hold_ok), 1);
    check(phase_ok, "R5 phase lengths", 32'(phase_ok), 1);
    check(ready_ok, "R7 ready low / busy high during frame", 32'(ready_ok), 1);
    check(cs_ok, "R9 select held through frame", 32'(cs_ok), 1);
    check(nocs_ok, "R9 select unused stays low", 32'(nocs_ok), 1);
    // R5/R8: completion exactly 49 half periods after acceptance
    check(done === 1'b1, "R8 done at completion", 32'(done), 1);
    check(in_ready === 1'b1 && busy === 1'b0, "R8 ready back with done",
          32'({in_ready, busy}), 32'h2);
    check(lcd_cs === 1'b0, "R9 select released at done", 32'(lcd_cs), 0);
    @(negedge clk);
    check(done === 1'b0, "R8 done single cycle", 32'(done), 0);
    check({lcd_sclk, lcd_sdata} === 2'b00, "R6 idle lines after frame",
          32'({lcd_sclk, lcd_sdata}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R6 reset state");

    for (int v = 0; v < NV; v++) begin
      run_frame(VECS[v][32], VECS[v][31:24], VECS[v][23:0], 1'b0);
    end

    // R7: producer activity during a frame is ignored
    run_frame(1'b0, 8'h3C, 24'hF830C0, 1'b1);

    // R6: reset in the middle of a frame
    @(negedge clk);
    in_valid = 1'b1; in_rs = 1'b1; in_data = 8'h99;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(busy === 1'b1, "R7 busy before mid-frame reset", 32'(busy), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R6 after mid-frame reset");

    // recovery after reset
    run_frame(1'b1, 8'h5A, 24'hFA50A0, 1'b0);

    summary();
    $finish;
  end
endmodule